// File: doc/BRIEF.md
# Reciprocal-Table Floating-Point Divider

This block divides one 18-bit floating-point number by another without iterating. It first forms the reciprocal of the divisor. The divisor's stored fraction addresses an on-chip reciprocal table, and the divisor's exponent is negated. The table output then becomes the mantissa of the reciprocal word. That word is multiplied by the dividend in a two-stage multiply section, which normalizes and packs the quotient.

The table is computed by a constant function during elaboration, so no data file is loaded. A dedicated delay stage covers the synchronous table read. The dividend and its flags travel beside the reciprocal path so that all of them reach the multiplier together. A new operand pair may be presented on every clock, and once the pipe is full one quotient leaves per clock. Rounding and special values such as infinity and NaN are not handled. A zero divisor is reported only by a saturated result.

Top module: `fdiv_recip`

## Requirements
- R1: Word layout. Bit 17 is the sign, bits 16:10 are a biased exponent (bias 63) and bits 9:0 are the fraction. The value is (-1)^s * 2^(e-63) * 1.f, and any word whose exponent field is 0 is treated as zero.
- R2: The quotient for an operand pair sampled on a rising edge appears with out_valid high on the fourth rising edge after that edge. Back-to-back inputs produce back-to-back outputs in the same order.
- R3: When the divisor fraction is zero (a power of two), the quotient is exact. Dividing by 1.0 (exponent 63, fraction 0) returns the dividend unchanged.
- R4: For other divisors the reciprocal mantissa is truncated to 10 fraction bits and the product is truncated. The magnitude field (bits 16:0) therefore lies between 0 and 3 codes below the exactly truncated quotient, and never above it.
- R5: For nonzero in-range results the quotient sign is the XOR of the operand signs.
- R6: A zero divisor gives the XOR of the signs, with exponent and fraction all ones, whatever the dividend is.
- R7: A zero dividend with a nonzero divisor gives the all-zero word.
- R8: A result exponent above 127 saturates to all-ones exponent and fraction, with the XOR sign.
- R9: A result exponent below 1 flushes to the all-zero word.
- R10: While reset is low, out_valid and quotient are 0.
- R11: A cycle with in_valid low produces no output: out_valid stays low four edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is present |
| dividend | input | 18 | Numerator word |
| divisor | input | 18 | Denominator word |
| out_valid | output | 1 | Quotient is present |
| quotient | output | 18 | Result word |

## Verification
The bench builds the block with its default widths: a 7-bit exponent and a 10-bit fraction. With a 1024-entry table, every divisor fraction can be swept one after another with dividend 1.0, so each table entry is checked against an exact reference. The narrow exponent lets overflow and underflow be reached with modest operands. Randomized mid-range operands, gaps in the input stream and zero operands then exercise the alignment of the side path and the priority of the saturation rules.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    // Per-operation flags carried alongside the data through every stage.
    typedef struct packed {
        logic vld;     // operation present
        logic a_zero;  // dividend exponent field is zero
        logic b_zero;  // divisor exponent field is zero
        logic sgn;     // XOR of operand signs
    } flags_t;

endpackage

// File: rtl/fdiv_recip_rom.sv
module fdiv_recip_rom #(
    parameter int FRAC_W = 10
) (
    input  logic              clk,
    input  logic [FRAC_W-1:0] addr,
    output logic [FRAC_W-1:0] data_q
);
    localparam int DEPTH = 1 << FRAC_W;

    typedef logic [FRAC_W-1:0] tab_t [DEPTH];

    // Entry i holds the fraction of 2/1.i (in [1,2)), truncated; entry 0
    // holds 0 since 1/1.0 is exactly 1.0 and needs no exponent shift.
    function automatic tab_t build_table();
        tab_t t;
        for (int i = 0; i < DEPTH; i++) begin
            if (i == 0) begin
                t[i] = '0;
            end else begin
                t[i] = FRAC_W'((longint'(1) << (2 * FRAC_W + 1)) / longint'(DEPTH + i)
                               - longint'(DEPTH));
            end
        end
        return t;
    endfunction

    localparam tab_t TABLE = build_table();

    always_ff @(posedge clk) begin
        data_q <= TABLE[addr];
    end

endmodule

// File: rtl/fdiv_recip_front.sv
module fdiv_recip_front
    import fdiv_pkg::*;
#(
    parameter int EXP_W  = 7,
    parameter int FRAC_W = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [EXP_W+FRAC_W:0]     dividend,
    input  logic [EXP_W+FRAC_W:0]     divisor,
    output flags_t                    fl_o,
    output logic [EXP_W+FRAC_W-1:0]   a_o,
    output logic signed [EXP_W+2:0]   rexp_o,
    output logic [FRAC_W:0]           rmant_o
);
    localparam int W    = 1 + EXP_W + FRAC_W;
    localparam int MW   = EXP_W + FRAC_W;
    localparam int XW   = EXP_W + 3;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    typedef struct packed {
        flags_t                fl;
        logic [MW-1:0]         a;
        logic signed [XW-1:0]  rexp;
    } hop_t;

    typedef struct packed {
        hop_t              h1;    // step 1: address captured, exponent negated
        logic [FRAC_W-1:0] addr;
        hop_t              h2;    // step 2: waiting for the table read
        hop_t              h3;    // step 3: reciprocal word reassembled
        logic [FRAC_W:0]   mant;
    } st_t;

    st_t st_d, st_q;
    logic [FRAC_W-1:0] rom_data;
    logic signed [XW-1:0] eb_s;
    logic signed [XW-1:0] adj_s;

    fdiv_recip_rom #(.FRAC_W(FRAC_W)) u_rom (
        .clk    (clk),
        .addr   (st_q.addr),
        .data_q (rom_data)
    );

    always_comb begin
        st_d = st_q;
        eb_s  = $signed(XW'(divisor[W-2 -: EXP_W]));
        adj_s = (divisor[FRAC_W-1:0] != '0) ? XW'(1) : XW'(0);

        st_d.h1.fl.vld    = in_valid;
        st_d.h1.fl.a_zero = (dividend[W-2 -: EXP_W] == '0);
        st_d.h1.fl.b_zero = (divisor[W-2 -: EXP_W] == '0);
        st_d.h1.fl.sgn    = dividend[W-1] ^ divisor[W-1];
        st_d.h1.a         = dividend[MW-1:0];
        st_d.h1.rexp      = $signed(XW'(2 * BIAS)) - eb_s - adj_s;
        st_d.addr         = divisor[FRAC_W-1:0];

        st_d.h2   = st_q.h1;
        st_d.h3   = st_q.h2;
        st_d.mant = {1'b1, rom_data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fl_o    = st_q.h3.fl;
    assign a_o     = st_q.h3.a;
    assign rexp_o  = st_q.h3.rexp;
    assign rmant_o = st_q.mant;

endmodule

// File: rtl/fdiv_mul_pipe.sv
module fdiv_mul_pipe
    import fdiv_pkg::*;
#(
    parameter int EXP_W  = 7,
    parameter int FRAC_W = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  flags_t                    fl_i,
    input  logic [EXP_W+FRAC_W-1:0]   a_i,
    input  logic signed [EXP_W+2:0]   rexp_i,
    input  logic [FRAC_W:0]           rmant_i,
    output logic                      o_valid,
    output logic [EXP_W+FRAC_W:0]     o_q
);
    localparam int W    = 1 + EXP_W + FRAC_W;
    localparam int XW   = EXP_W + 3;
    localparam int PW   = 2 * FRAC_W + 2;
    localparam int HW   = FRAC_W + 2;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX = (1 << EXP_W) - 1;

    typedef struct packed {
        flags_t                fl;
        logic [HW-1:0]         hi;    // product bits above the discarded half
        logic signed [XW-1:0]  esum;
        logic                  vld;
        logic [W-1:0]          q;
    } st_t;

    st_t st_d, st_q;
    logic [FRAC_W-1:0]    nm;
    logic signed [XW-1:0] ne;
    logic [W-1:0]         res;

    always_comb begin
        st_d = st_q;

        // Multiply step: mantissa product and exponent sum.
        st_d.fl   = fl_i;
        st_d.hi   = HW'((PW'({1'b1, a_i[FRAC_W-1:0]}) * PW'(rmant_i)) >> FRAC_W);
        st_d.esum = $signed(XW'(a_i[EXP_W+FRAC_W-1 -: EXP_W])) + rexp_i
                    - $signed(XW'(BIAS));

        // Normalize step: product lies in [1,4), at most one right shift.
        if (st_q.hi[HW-1]) begin
            nm = st_q.hi[HW-2 -: FRAC_W];
            ne = st_q.esum + XW'(1);
        end else begin
            nm = st_q.hi[HW-3 -: FRAC_W];
            ne = st_q.esum;
        end

        if (st_q.fl.b_zero) begin
            res = {st_q.fl.sgn, {(W-1){1'b1}}};
        end else if (st_q.fl.a_zero) begin
            res = '0;
        end else if (ne > $signed(XW'(EMAX))) begin
            res = {st_q.fl.sgn, {(W-1){1'b1}}};
        end else if (ne < $signed(XW'(1))) begin
            res = '0;
        end else begin
            res = {st_q.fl.sgn, ne[EXP_W-1:0], nm};
        end

        st_d.vld = st_q.fl.vld;
        if (st_q.fl.vld) begin
            st_d.q = res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign o_valid = st_q.vld;
    assign o_q     = st_q.q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid == $past(fl_i.vld, 2)); // R2

    AST_ZERO_DIVISOR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_i.vld && fl_i.b_zero) |-> ##2 (o_valid && o_q[W-2:0] == {(W-1){1'b1}}
                                           && o_q[W-1] == $past(fl_i.sgn, 2))); // R6

endmodule

// File: rtl/fdiv_recip.sv
module fdiv_recip
    import fdiv_pkg::*;
#(
    parameter int EXP_W  = 7,
    parameter int FRAC_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [EXP_W+FRAC_W:0] dividend,
    input  logic [EXP_W+FRAC_W:0] divisor,
    output logic                  out_valid,
    output logic [EXP_W+FRAC_W:0] quotient
);
    localparam int W    = 1 + EXP_W + FRAC_W;
    localparam int MW   = EXP_W + FRAC_W;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    flags_t                  fl;
    logic [MW-1:0]           a_al;
    logic signed [EXP_W+2:0] rexp;
    logic [FRAC_W:0]         rmant;

    fdiv_recip_front #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .dividend (dividend),
        .divisor  (divisor),
        .fl_o     (fl),
        .a_o      (a_al),
        .rexp_o   (rexp),
        .rmant_o  (rmant)
    );

    fdiv_mul_pipe #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .fl_i    (fl),
        .a_i     (a_al),
        .rexp_i  (rexp),
        .rmant_i (rmant),
        .o_valid (out_valid),
        .o_q     (quotient)
    );

    AST_BUBBLE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##5 !out_valid); // R11

    AST_ZERO_DIVIDEND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dividend[W-2 -: EXP_W] == '0 && divisor[W-2 -: EXP_W] != '0)
        |-> ##5 (out_valid && quotient == '0)); // R7

    AST_DIV_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dividend[W-2 -: EXP_W] != '0 && divisor[W-2:0] == {EXP_W'(BIAS), FRAC_W'(0)})
        |-> ##5 (out_valid && quotient == {$past(dividend[W-1] ^ divisor[W-1], 5),
                                           $past(dividend[MW-1:0], 5)})); // R3

endmodule

// File: tb/test_fdiv_recip.sv
module test_fdiv_recip;

    localparam int EXP_W  = 7;
    localparam int FRAC_W = 10;
    localparam int W      = 1 + EXP_W + FRAC_W;
    localparam int BIAS   = 63;

    typedef struct {
        int           stamp;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] expv;
        int           tol;
        int           req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         out_valid;
    logic [W-1:0] quotient;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    item_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    fdiv_recip #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_fdiv_recip (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .dividend  (dividend),
        .divisor   (divisor),
        .out_valid (out_valid),
        .quotient  (quotient)
    );

    function automatic logic [W-1:0] mk(input logic s, input int e, input int f);
        return {s, 7'(e), 10'(f)};
    endfunction

    // Reference from the requirements: exact quotient truncated to the format.
    function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
        int ea, eb, qa, qb, m, e;
        logic s;
        s  = a[17] ^ b[17];
        ea = int'(a[16:10]);
        eb = int'(b[16:10]);
        if (eb == 0) return {s, 17'h1FFFF};           // R6
        if (ea == 0) return '0;                       // R7
        qa = 1024 + int'(a[9:0]);
        qb = 1024 + int'(b[9:0]);
        e  = ea - eb + BIAS;
        if (qa >= qb) m = (qa * 1024) / qb;
        else begin m = (qa * 2048) / qb; e = e - 1; end
        if (e > 127) return {s, 17'h1FFFF};           // R8
        if (e < 1)   return '0;                       // R9
        return {s, 7'(e), 10'(m)};
    endfunction

    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input int req);
        item_t it;
        @(negedge clk);
        dividend = a;
        divisor  = b;
        in_valid = 1'b1;
        it.stamp = cyc + 1;
        it.a     = a;
        it.b     = b;
        it.expv  = model(a, b);
        it.tol   = (b[9:0] == '0 || b[16:10] == '0 || a[16:10] == '0) ? 0 : 3; // R3 exact, R4 bound
        it.req   = req;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            dividend = $urandom;
            divisor  = $urandom;
        end
    endtask

    // Monitor: pops the scoreboard as results appear.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11: out_valid high with nothing pending, got %h expected no output", quotient);
            end else begin
                item_t it;
                int diff;
                it = sb.pop_front();
                checks++;
                if (cyc != it.stamp + 4) begin          // R2 latency
                    errors++;
                    $display("FAIL R2: result at cycle %0d expected %0d", cyc, it.stamp + 4);
                end
                checks++;
                diff = int'(it.expv[16:0]) - int'(quotient[16:0]);
                if (quotient[17] != it.expv[17] || diff < 0 || diff > it.tol) begin
                    errors++;
                    $display("FAIL R%0d: %h / %h got %h expected %h (tol %0d)",
                             it.req, it.a, it.b, quotient, it.expv, it.tol);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (4) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || quotient !== '0) begin
            errors++;
            $display("FAIL R10: out_valid=%b quotient=%h expected 0 and 0", out_valid, quotient);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1/R4/R5: worked example 24.046875 / -25.40625
        send(mk(0, 67, 10'b1000000011), mk(1, 67, 10'b1001011010), 4);
        send(mk(1, 70, 300), mk(1, 60, 777), 5);             // R5 neg/neg
        send(mk(0, 50, 12), mk(1, 55, 1000), 5);             // R5 pos/neg
        // R3: divide by 1.0 and powers of two
        send(mk(1, 80, 555), mk(0, BIAS, 0), 3);
        send(mk(0, 70, 1023), mk(0, 66, 0), 3);
        send(mk(0, 40, 1), mk(1, 30, 0), 3);
        idle(3);                                             // R11 bubble
        // R6: zero divisor, with nonzero and zero dividend
        send(mk(1, 90, 77), mk(0, 0, 123), 6);
        send(mk(0, 0, 0), mk(1, 0, 0), 6);
        // R7: zero dividend
        send(mk(1, 0, 400), mk(0, 70, 9), 7);
        // R8: overflow
        send(mk(0, 120, 5), mk(1, 10, 900), 8);
        send(mk(1, 127, 1023), mk(1, 1, 0), 8);
        // R9: underflow
        send(mk(0, 5, 5), mk(0, 120, 300), 9);
        send(mk(1, 1, 0), mk(0, 127, 1023), 9);
        idle(1);                                             // R11 single gap

        // R4: every divisor fraction against dividend 1.0
        for (int f = 0; f < 1024; f++) begin
            send(mk(0, BIAS, 0), mk(f[0], BIAS, f), 4);
        end

        // R4/R5: mixed random mid-range operands with occasional gaps (R11)
        for (int i = 0; i < 300; i++) begin
            send(mk(1'($urandom), int'($urandom_range(40, 86)), int'($urandom_range(0, 1023))),
                 mk(1'($urandom), int'($urandom_range(40, 86)), int'($urandom_range(0, 1023))), 4);
            if ((i % 37) == 0) idle(2);
        end

        idle(10);
        // R2: every item produced exactly once
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d results missing, expected 0 pending", sb.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule